// File: doc/BRIEF.md
# Global-Qualified MESI Snoop Controller

This block keeps the four-state MESI coherency state of a small direct-mapped line directory and sits between a local processor and a shared bus. The processor side looks up lines for local reads and writes. It runs its own bus transactions when a line must be filled, upgraded or evicted. Each of these transactions carries a global flag that tells the other agents whether to snoop it.

A second, independent lookup port watches the bus. Only transactions flagged as global are compared against the directory. A conflict with a locally modified line is answered by asking the requester to retry, and the dirty line is queued for a copy-back. The requester then repeats its transaction, and by that time memory holds current data. A snoop read that finds a clean copy answers with a shared indication. Data storage, bus arbitration and address translation sit outside the block.

Addresses are split into a byte offset in bits [1:0], a line index in bits [4:2] and a tag in bits [15:5]. These are the default field positions. Snoop ops are encoded as 00 read, 01 write, 10 read-with-intent-to-modify and 11 kill. Own bus ops are encoded as 00 read, 01 read-with-intent-to-modify, 10 kill and 11 write-back.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: After synchronous reset every line is Invalid and cpu_ack, bus_req, snp_retry, snp_shared and cb_req are low.
- R2: A local read miss raises bus_req with bus_op 00, with bus_addr equal to the request address, and with bus_gbl equal to the page's cpu_coh attribute. The line becomes Shared if bus_shr is high with bus_done and Exclusive otherwise. cpu_ack pulses one cycle after bus_done.
- R3: A local read hit pulses cpu_ack in the cycle after the request is taken and raises no bus request.
- R4: A local write that hits an Exclusive or Modified line is acknowledged without a bus request and leaves the line Modified.
- R5: A local write that hits a Shared line issues bus_op 10 with bus_gbl high, and the line becomes Modified when bus_done arrives. If a snoop invalidated the line while the kill was outstanding, the block follows on with a bus_op 01 fill instead.
- R6: A local write miss fills with bus_op 01 and leaves the line Modified.
- R7: A miss whose victim line is Modified first issues bus_op 11 at the victim's address with bus_gbl low, and then issues the fill.
- R8: A snoop with snp_gbl low causes no compare, no response and no state change.
- R9: A global snoop read that hits a Shared or Exclusive line raises snp_shared one cycle later, and an Exclusive line becomes Shared. A miss gives no response.
- R10: A global snoop read that hits a Modified line raises snp_retry one cycle later. It also raises cb_req with cb_addr equal to the snooped address, and the line becomes Shared when cb_done arrives.
- R11: A global snoop with op 01, 10 or 11 invalidates a Shared or Exclusive line without retry. On a Modified line it raises snp_retry and cb_req, and the line becomes Invalid at cb_done.
- R12: While a copy-back is pending, every global snoop is retried. A local access to the line being copied back is held until cb_done.
- R13: A snoop and a local access to different lines in the same cycle are both served in that cycle. If both would update the same line, the snoop goes first and the local access is re-evaluated on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Local access request, held until cpu_ack |
| cpu_we | input | 1 | Local access is a write |
| cpu_addr | input | ADDR_W | Local access address |
| cpu_coh | input | 1 | Coherency-required attribute of the accessed page |
| cpu_ack | output | 1 | One-cycle completion of the local access |
| bus_req | output | 1 | Own bus transaction outstanding |
| bus_op | output | 2 | Own transaction kind (00 read, 01 rwitm, 10 kill, 11 write-back) |
| bus_addr | output | ADDR_W | Own transaction address |
| bus_gbl | output | 1 | Own transaction must be snooped by others |
| bus_done | input | 1 | Own transaction completed |
| bus_shr | input | 1 | Shared response seen during own fill, valid with bus_done |
| snp_valid | input | 1 | Bus address tenure to examine |
| snp_gbl | input | 1 | Observed transaction is global |
| snp_op | input | 2 | Observed transaction kind (00 read, 01 write, 10 rwitm, 11 kill) |
| snp_addr | input | ADDR_W | Observed address |
| snp_retry | output | 1 | Address-retry response, one cycle after snp_valid |
| snp_shared | output | 1 | Shared response, one cycle after snp_valid |
| cb_req | output | 1 | Copy-back of a modified line pending |
| cb_addr | output | ADDR_W | Address of the line to copy back |
| cb_done | input | 1 | Copy-back completed |

## Verification
The assertions check, on every cycle, that retry and shared are never raised together and that a non-global snoop never draws a response. They also check that a copy-back request only starts together with a retry, that a pending copy-back retries every global snoop, and that outstanding bus and copy-back requests keep their addresses steady. Further per-cycle checks are that a kill is always global and that the two directory writers never hit one line in one cycle. The actual MESI transitions are visible only through later behaviour, so the bench scenarios have to show them. A later local write that needs a kill reveals a Shared line, and a later snoop that is retried reveals a Modified one. The same applies to the lost-kill follow-on fill, the victim write-back ordering and the same-cycle collision between a snoop and a local upgrade.

// File: rtl/mesi_pkg.sv
// Shared types of the MESI snoop controller: line states, snoop op codes,
// own bus op codes and the processor-side sequencer states.
package mesi_pkg;

    typedef enum logic [1:0] {
        ST_I = 2'b00,
        ST_S = 2'b01,
        ST_E = 2'b10,
        ST_M = 2'b11
    } mesi_t;

    typedef enum logic [1:0] {
        SN_READ  = 2'b00,
        SN_WRITE = 2'b01,
        SN_RWITM = 2'b10,
        SN_KILL  = 2'b11
    } snp_op_t;

    typedef enum logic [1:0] {
        BO_READ  = 2'b00,
        BO_RWITM = 2'b01,
        BO_KILL  = 2'b10,
        BO_WBACK = 2'b11
    } bus_op_t;

    typedef enum logic [1:0] {
        CS_IDLE = 2'b00,
        CS_VICT = 2'b01,
        CS_FILL = 2'b10,
        CS_KILL = 2'b11
    } cstate_t;

endpackage

// File: rtl/mesi_tag_array.sv
// Direct-mapped tag and state directory with two asynchronous read ports
// (processor side and snoop side) and two write ports.
// Assumes the two writers never target the same line in one cycle; the
// processor-side writer has priority if they ever do.
module mesi_tag_array
    import mesi_pkg::*;
#(
    parameter int IDX_W = 3,
    parameter int TAG_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] a_idx,
    output logic [TAG_W-1:0] a_tag,
    output mesi_t            a_st,
    input  logic [IDX_W-1:0] b_idx,
    output logic [TAG_W-1:0] b_tag,
    output mesi_t            b_st,
    input  logic             s_we,
    input  logic [IDX_W-1:0] s_idx,
    input  mesi_t            s_st,
    input  logic             c_we,
    input  logic [IDX_W-1:0] c_idx,
    input  logic [TAG_W-1:0] c_tag,
    input  mesi_t            c_st
);
    localparam int LINES = 1 << IDX_W;

    logic [TAG_W-1:0] tags [LINES];
    mesi_t            sts  [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        // Per-line state: reset to Invalid, then processor or snoop update.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sts[g]  <= ST_I;
                tags[g] <= '0;
            end else if (c_we && c_idx == IDX_W'(g)) begin
                sts[g]  <= c_st;
                tags[g] <= c_tag;
            end else if (s_we && s_idx == IDX_W'(g)) begin
                sts[g]  <= s_st;
            end
        end
    end

    // Read ports: plain indexed lookups.
    always_comb begin
        a_tag = tags[a_idx];
        a_st  = sts[a_idx];
        b_tag = tags[b_idx];
        b_st  = sts[b_idx];
    end

    a_r13_one_writer: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_we && c_we && s_idx == c_idx));

endmodule

// File: rtl/mesi_snoop_side.sv
// Snoop engine: compares global bus addresses on the directory's second
// port, registers retry/shared responses, and holds one pending copy-back.
// Assumes cb_done is never asserted together with the owner's bus_done and
// that snoop tenures do not coincide with the owner's own completions.
module mesi_snoop_side
    import mesi_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 3,
    parameter int OFS_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snp_valid,
    input  logic              snp_gbl,
    input  logic [1:0]        snp_op,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_retry,
    output logic              snp_shared,
    output logic              cb_req,
    output logic [ADDR_W-1:0] cb_addr,
    input  logic              cb_done,
    output logic [IDX_W-1:0]  b_idx,
    input  logic [ADDR_W-IDX_W-OFS_W-1:0] b_tag,
    input  mesi_t             b_st,
    output logic              s_we,
    output logic [IDX_W-1:0]  s_idx,
    output mesi_t             s_st,
    input  logic [IDX_W-1:0]  cpu_idx,
    output logic              cpu_blk
);
    localparam int TAG_W = ADDR_W - IDX_W - OFS_W;

    logic              pend_q, pend_d;
    logic [ADDR_W-1:0] cb_addr_q, cb_addr_d;
    mesi_t             cb_nst_q, cb_nst_d;
    logic              retry_q, retry_d, shared_q, shared_d;

    logic [IDX_W-1:0]  sn_idx, cb_idx;
    logic [TAG_W-1:0]  sn_tag, cb_tag;
    logic              is_glob, is_inv, hit;

    // Field split of the snooped and the pending addresses.
    always_comb begin
        sn_idx  = snp_addr[OFS_W +: IDX_W];
        sn_tag  = snp_addr[ADDR_W-1 -: TAG_W];
        cb_idx  = cb_addr_q[OFS_W +: IDX_W];
        cb_tag  = cb_addr_q[ADDR_W-1 -: TAG_W];
        b_idx   = pend_q ? cb_idx : sn_idx;
        is_glob = snp_valid && snp_gbl;
        is_inv  = snp_op_t'(snp_op) != SN_READ;
        hit     = (b_st != ST_I) && (b_tag == sn_tag);
    end

    // Snoop decision: responses, directory update and copy-back bookkeeping.
    always_comb begin
        pend_d    = pend_q;
        cb_addr_d = cb_addr_q;
        cb_nst_d  = cb_nst_q;
        retry_d   = 1'b0;
        shared_d  = 1'b0;
        s_we      = 1'b0;
        s_idx     = b_idx;
        s_st      = ST_I;
        if (pend_q) begin
            retry_d = is_glob;
            if (cb_done) begin
                pend_d = 1'b0;
                if (b_st == ST_M && b_tag == cb_tag) begin
                    s_we = 1'b1;
                    s_st = cb_nst_q;
                end
            end
        end else if (is_glob && hit) begin
            if (b_st == ST_M) begin
                retry_d   = 1'b1;
                pend_d    = 1'b1;
                cb_addr_d = snp_addr;
                cb_nst_d  = is_inv ? ST_I : ST_S;
            end else if (is_inv) begin
                s_we = 1'b1;
                s_st = ST_I;
            end else begin
                shared_d = 1'b1;
                if (b_st == ST_E) begin
                    s_we = 1'b1;
                    s_st = ST_S;
                end
            end
        end
    end

    // Hold-off for the processor side when both would touch one line.
    always_comb begin
        cpu_blk = pend_q ? (cb_idx == cpu_idx)
                         : (is_glob && hit && sn_idx == cpu_idx);
    end

    // Response and pending copy-back registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q    <= 1'b0;
            cb_addr_q <= '0;
            cb_nst_q  <= ST_I;
            retry_q   <= 1'b0;
            shared_q  <= 1'b0;
        end else begin
            pend_q    <= pend_d;
            cb_addr_q <= cb_addr_d;
            cb_nst_q  <= cb_nst_d;
            retry_q   <= retry_d;
            shared_q  <= shared_d;
        end
    end

    assign snp_retry  = retry_q;
    assign snp_shared = shared_q;
    assign cb_req     = pend_q;
    assign cb_addr    = cb_addr_q;

    a_r8_nongbl_silent: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid && !snp_gbl |=> !snp_retry && !snp_shared);
    a_r9_resp_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(snp_retry && snp_shared));
    a_r10_cb_with_retry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cb_req) |-> snp_retry);
    a_r11_cb_hold: assert property (@(posedge clk) disable iff (!rst_n)
        cb_req && !cb_done |=> cb_req && $stable(cb_addr));
    a_r12_pend_retry: assert property (@(posedge clk) disable iff (!rst_n)
        cb_req && snp_valid && snp_gbl |=> snp_retry);

endmodule

// File: rtl/mesi_cpu_side.sv
// Processor-side sequencer: looks up local accesses, performs silent
// upgrades, and runs its own bus transactions (victim write-back, fill,
// kill) with the global flag taken from the page attribute.
// Assumes cpu_req is held until cpu_ack and bus_done is a one-cycle pulse.
module mesi_cpu_side
    import mesi_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 3,
    parameter int OFS_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_coh,
    output logic              cpu_ack,
    input  logic              blk,
    output logic [IDX_W-1:0]  lk_idx,
    input  logic [ADDR_W-IDX_W-OFS_W-1:0] lk_tag,
    input  mesi_t             lk_st,
    output logic              bus_req,
    output bus_op_t           bus_op,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_gbl,
    input  logic              bus_done,
    input  logic              bus_shr,
    output logic              c_we,
    output logic [IDX_W-1:0]  c_idx,
    output logic [ADDR_W-IDX_W-OFS_W-1:0] c_tag,
    output mesi_t             c_st
);
    localparam int TAG_W = ADDR_W - IDX_W - OFS_W;

    cstate_t           st_q, st_d;
    logic [ADDR_W-1:0] addr_q, addr_d;
    logic              we_q, we_d, coh_q, coh_d, ack_q, ack_d;
    logic [ADDR_W-1:0] cur_addr;
    logic [TAG_W-1:0]  cur_tag;
    logic              hit;

    // Address under lookup: the live request when idle, else the latched one.
    always_comb begin
        cur_addr = (st_q == CS_IDLE) ? cpu_addr : addr_q;
        cur_tag  = cur_addr[ADDR_W-1 -: TAG_W];
        lk_idx   = cur_addr[OFS_W +: IDX_W];
        hit      = (lk_st != ST_I) && (lk_tag == cur_tag);
    end

    // Next-state logic of the sequencer and its directory writes.
    always_comb begin
        st_d   = st_q;
        addr_d = addr_q;
        we_d   = we_q;
        coh_d  = coh_q;
        ack_d  = 1'b0;
        c_we   = 1'b0;
        c_idx  = lk_idx;
        c_tag  = cur_tag;
        c_st   = ST_I;
        case (st_q)
            CS_IDLE: begin
                if (cpu_req && !ack_q && !blk) begin
                    addr_d = cpu_addr;
                    we_d   = cpu_we;
                    coh_d  = cpu_coh;
                    if (hit) begin
                        if (!cpu_we || lk_st == ST_M) begin
                            ack_d = 1'b1;
                        end else if (lk_st == ST_E) begin
                            c_we  = 1'b1;
                            c_st  = ST_M;
                            ack_d = 1'b1;
                        end else begin
                            st_d = CS_KILL;
                        end
                    end else begin
                        st_d = (lk_st == ST_M) ? CS_VICT : CS_FILL;
                    end
                end
            end
            CS_VICT: begin
                if (bus_done) begin
                    c_we  = 1'b1;
                    c_tag = lk_tag;
                    c_st  = ST_I;
                    st_d  = CS_FILL;
                end
            end
            CS_FILL: begin
                if (bus_done) begin
                    c_we  = 1'b1;
                    c_st  = we_q ? ST_M : (bus_shr ? ST_S : ST_E);
                    ack_d = 1'b1;
                    st_d  = CS_IDLE;
                end
            end
            default: begin
                if (bus_done) begin
                    if (hit) begin
                        c_we  = 1'b1;
                        c_st  = ST_M;
                        ack_d = 1'b1;
                        st_d  = CS_IDLE;
                    end else begin
                        st_d = CS_FILL;
                    end
                end
            end
        endcase
    end

    // Sequencer registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= CS_IDLE;
            addr_q <= '0;
            we_q   <= 1'b0;
            coh_q  <= 1'b0;
            ack_q  <= 1'b0;
        end else begin
            st_q   <= st_d;
            addr_q <= addr_d;
            we_q   <= we_d;
            coh_q  <= coh_d;
            ack_q  <= ack_d;
        end
    end

    // Own bus transaction outputs, decoded from the sequencer state.
    always_comb begin
        bus_req  = st_q != CS_IDLE;
        bus_addr = addr_q;
        bus_gbl  = coh_q;
        bus_op   = we_q ? BO_RWITM : BO_READ;
        if (st_q == CS_VICT) begin
            bus_op   = BO_WBACK;
            bus_gbl  = 1'b0;
            bus_addr = {lk_tag, addr_q[OFS_W +: IDX_W], {OFS_W{1'b0}}};
        end else if (st_q == CS_KILL) begin
            bus_op  = BO_KILL;
            bus_gbl = 1'b1;
        end
    end

    assign cpu_ack = ack_q;

    a_r5_kill_global: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_op == BO_KILL |-> bus_gbl);
    a_r2_bus_hold: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_done |=> bus_req && $stable(bus_addr) && $stable(bus_op));
    a_r3_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack |=> !cpu_ack);

endmodule

// File: rtl/mesi_snoop_ctrl.sv
// Top of the MESI snoop controller: directory with a processor port and a
// dedicated snoop port, the processor-side sequencer and the snoop engine.
// Assumes bus_done and cb_done never coincide, and no snoop tenure lands in
// the cycle of the owner's own bus completion.
module mesi_snoop_ctrl
    import mesi_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 3,
    parameter int OFS_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_coh,
    output logic              cpu_ack,
    output logic              bus_req,
    output logic [1:0]        bus_op,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_gbl,
    input  logic              bus_done,
    input  logic              bus_shr,
    input  logic              snp_valid,
    input  logic              snp_gbl,
    input  logic [1:0]        snp_op,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_retry,
    output logic              snp_shared,
    output logic              cb_req,
    output logic [ADDR_W-1:0] cb_addr,
    input  logic              cb_done
);
    localparam int TAG_W = ADDR_W - IDX_W - OFS_W;

    logic [IDX_W-1:0] a_idx, b_idx, s_idx, c_idx;
    logic [TAG_W-1:0] a_tag, b_tag, c_tag;
    mesi_t            a_st, b_st, s_st, c_st;
    logic             s_we, c_we, blk;
    bus_op_t          bus_op_e;

    mesi_tag_array #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_dir (
        .clk(clk), .rst_n(rst_n),
        .a_idx(a_idx), .a_tag(a_tag), .a_st(a_st),
        .b_idx(b_idx), .b_tag(b_tag), .b_st(b_st),
        .s_we(s_we), .s_idx(s_idx), .s_st(s_st),
        .c_we(c_we), .c_idx(c_idx), .c_tag(c_tag), .c_st(c_st)
    );

    mesi_cpu_side #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFS_W(OFS_W)) u_cpu (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_coh(cpu_coh), .cpu_ack(cpu_ack), .blk(blk),
        .lk_idx(a_idx), .lk_tag(a_tag), .lk_st(a_st),
        .bus_req(bus_req), .bus_op(bus_op_e), .bus_addr(bus_addr),
        .bus_gbl(bus_gbl), .bus_done(bus_done), .bus_shr(bus_shr),
        .c_we(c_we), .c_idx(c_idx), .c_tag(c_tag), .c_st(c_st)
    );

    mesi_snoop_side #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFS_W(OFS_W)) u_snp (
        .clk(clk), .rst_n(rst_n),
        .snp_valid(snp_valid), .snp_gbl(snp_gbl), .snp_op(snp_op),
        .snp_addr(snp_addr), .snp_retry(snp_retry), .snp_shared(snp_shared),
        .cb_req(cb_req), .cb_addr(cb_addr), .cb_done(cb_done),
        .b_idx(b_idx), .b_tag(b_tag), .b_st(b_st),
        .s_we(s_we), .s_idx(s_idx), .s_st(s_st),
        .cpu_idx(a_idx), .cpu_blk(blk)
    );

    assign bus_op = bus_op_e;

    a_r12_cb_serial: assert property (@(posedge clk) disable iff (!rst_n)
        !(cb_done && bus_done));

endmodule

// File: tb/test_mesi_snoop_ctrl.sv
`timescale 1ns/1ps
module test_mesi_snoop_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 0, cpu_we = 0, cpu_coh = 0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_ack;
    logic        bus_req, bus_gbl;
    logic [1:0]  bus_op;
    logic [15:0] bus_addr;
    logic        bus_done = 0, bus_shr = 0;
    logic        snp_valid = 0, snp_gbl = 0;
    logic [1:0]  snp_op = '0;
    logic [15:0] snp_addr = '0;
    logic        snp_retry, snp_shared, cb_req;
    logic [15:0] cb_addr;
    logic        cb_done = 0;

    int checks = 0, fails = 0;
    bit finished = 0;
    logic r_retry, r_shared;

    always #5 clk = ~clk;

    mesi_snoop_ctrl i_mesi_snoop_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_coh(cpu_coh), .cpu_ack(cpu_ack),
        .bus_req(bus_req), .bus_op(bus_op), .bus_addr(bus_addr),
        .bus_gbl(bus_gbl), .bus_done(bus_done), .bus_shr(bus_shr),
        .snp_valid(snp_valid), .snp_gbl(snp_gbl), .snp_op(snp_op),
        .snp_addr(snp_addr), .snp_retry(snp_retry), .snp_shared(snp_shared),
        .cb_req(cb_req), .cb_addr(cb_addr), .cb_done(cb_done)
    );

    function automatic logic [15:0] mk(input int tag, input int idx);
        return {tag[10:0], idx[2:0], 2'b00};
    endfunction

    task automatic chk(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic cpu_go(input logic we, input logic [15:0] a, input logic coh);
        cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_coh = coh;
    endtask

    task automatic wait_bus();
        for (int i = 0; i < 20; i++) begin
            if (bus_req) break;
            @(negedge clk);
        end
    endtask

    task automatic bus_finish(input logic shr);
        bus_done = 1; bus_shr = shr;
        @(negedge clk);
        bus_done = 0; bus_shr = 0;
    endtask

    task automatic wait_ack(input string rq);
        bit seen = 0;
        for (int i = 0; i < 20; i++) begin
            if (cpu_ack) begin seen = 1; break; end
            @(negedge clk);
        end
        chk(rq, "cpu_ack", {31'b0, seen}, 1);
        cpu_req = 0;
    endtask

    task automatic snoop(input logic [1:0] op, input logic gbl, input logic [15:0] a);
        snp_valid = 1; snp_gbl = gbl; snp_op = op; snp_addr = a;
        @(negedge clk);
        snp_valid = 0;
        r_retry = snp_retry; r_shared = snp_shared;
    endtask

    task automatic cb_finish();
        cb_done = 1;
        @(negedge clk);
        cb_done = 0;
    endtask

    task automatic fill(input logic we, input logic [15:0] a, input logic coh,
                        input logic shr, input string rq);
        cpu_go(we, a, coh);
        @(negedge clk);
        wait_bus();
        chk(rq, "fill bus_req", {31'b0, bus_req}, 1);
        bus_finish(shr);
        wait_ack(rq);
    endtask

    task automatic t_reset();
        chk("R1", "cpu_ack", {31'b0, cpu_ack}, 0);
        chk("R1", "bus_req", {31'b0, bus_req}, 0);
        chk("R1", "snp_retry", {31'b0, snp_retry}, 0);
        chk("R1", "snp_shared", {31'b0, snp_shared}, 0);
        chk("R1", "cb_req", {31'b0, cb_req}, 0);
    endtask

    task automatic t_read_fill();
        logic [15:0] a = mk(5, 1);
        cpu_go(0, a, 1);
        @(negedge clk);
        wait_bus();
        chk("R1", "miss after reset", {31'b0, bus_req}, 1);
        chk("R2", "bus_op read", {30'b0, bus_op}, 0);
        chk("R2", "bus_addr", {16'b0, bus_addr}, {16'b0, a});
        chk("R2", "bus_gbl from attr", {31'b0, bus_gbl}, 1);
        bus_finish(0);
        wait_ack("R2");
        @(negedge clk);
        cpu_go(0, a, 1);
        @(negedge clk);
        chk("R3", "hit ack", {31'b0, cpu_ack}, 1);
        chk("R3", "no bus", {31'b0, bus_req}, 0);
        cpu_req = 0;
        @(negedge clk);
        cpu_go(1, a, 1);
        @(negedge clk);
        chk("R4", "write E ack", {31'b0, cpu_ack}, 1);
        chk("R4", "write E no bus", {31'b0, bus_req}, 0);
        cpu_req = 0;
        @(negedge clk);
        cpu_go(1, a, 1);
        @(negedge clk);
        chk("R4", "write M ack", {31'b0, cpu_ack}, 1);
        chk("R4", "write M no bus", {31'b0, bus_req}, 0);
        cpu_req = 0;
        @(negedge clk);
    endtask

    task automatic t_copyback();
        logic [15:0] a = mk(5, 1);
        snoop(2'b00, 1, a);
        chk("R10", "retry on M", {31'b0, r_retry}, 1);
        chk("R10", "no shared on M", {31'b0, r_shared}, 0);
        chk("R10", "cb_req", {31'b0, cb_req}, 1);
        chk("R10", "cb_addr", {16'b0, cb_addr}, {16'b0, a});
        snoop(2'b00, 1, mk(9, 2));
        chk("R12", "retry while pending", {31'b0, r_retry}, 1);
        cpu_go(0, a, 1);
        repeat (3) @(negedge clk);
        chk("R12", "cpu held", {31'b0, cpu_ack}, 0);
        chk("R12", "cpu no bus", {31'b0, bus_req}, 0);
        cb_finish();
        wait_ack("R12");
        chk("R10", "line kept after cb", {31'b0, bus_req}, 0);
        chk("R10", "cb_req cleared", {31'b0, cb_req}, 0);
        @(negedge clk);
        snoop(2'b00, 1, a);
        chk("R10", "now Shared", {31'b0, r_shared}, 1);
        chk("R10", "no retry on S", {31'b0, r_retry}, 0);
    endtask

    task automatic t_kill();
        logic [15:0] c = mk(3, 2);
        cpu_go(0, c, 0);
        @(negedge clk);
        wait_bus();
        chk("R2", "gbl low from attr", {31'b0, bus_gbl}, 0);
        bus_finish(1);
        wait_ack("R2");
        @(negedge clk);
        cpu_go(1, c, 0);
        @(negedge clk);
        wait_bus();
        chk("R5", "kill op", {30'b0, bus_op}, 2);
        chk("R5", "kill gbl", {31'b0, bus_gbl}, 1);
        chk("R5", "kill addr", {16'b0, bus_addr}, {16'b0, c});
        bus_finish(0);
        wait_ack("R5");
        @(negedge clk);
        snoop(2'b00, 0, c);
        chk("R8", "nonglobal no retry", {31'b0, r_retry}, 0);
        chk("R8", "nonglobal no shared", {31'b0, r_shared}, 0);
        chk("R8", "nonglobal no cb", {31'b0, cb_req}, 0);
        snoop(2'b10, 1, c);
        chk("R11", "rwitm on M retry", {31'b0, r_retry}, 1);
        chk("R11", "rwitm on M cb", {31'b0, cb_req}, 1);
        cb_finish();
        cpu_go(0, c, 0);
        @(negedge clk);
        wait_bus();
        chk("R11", "M invalidated", {31'b0, bus_req}, 1);
        chk("R11", "refill read", {30'b0, bus_op}, 0);
        bus_finish(0);
        wait_ack("R11");
        @(negedge clk);
    endtask

    task automatic t_snoop_excl();
        logic [15:0] d = mk(7, 3);
        fill(0, d, 1, 0, "R9");
        @(negedge clk);
        snoop(2'b00, 1, mk(8, 3));
        chk("R9", "tag miss no shared", {31'b0, r_shared}, 0);
        chk("R9", "tag miss no retry", {31'b0, r_retry}, 0);
        snoop(2'b00, 1, d);
        chk("R9", "E shared", {31'b0, r_shared}, 1);
        chk("R9", "E no retry", {31'b0, r_retry}, 0);
        cpu_go(1, d, 1);
        @(negedge clk);
        wait_bus();
        chk("R9", "E became S (kill)", {30'b0, bus_op}, 2);
        bus_finish(0);
        wait_ack("R9");
        @(negedge clk);
    endtask

    task automatic t_inval_clean();
        logic [15:0] f = mk(2, 4);
        fill(0, f, 1, 1, "R11");
        @(negedge clk);
        snoop(2'b01, 1, f);
        chk("R11", "write on S no retry", {31'b0, r_retry}, 0);
        chk("R11", "write on S no shared", {31'b0, r_shared}, 0);
        chk("R11", "write on S no cb", {31'b0, cb_req}, 0);
        cpu_go(0, f, 1);
        @(negedge clk);
        wait_bus();
        chk("R11", "S invalidated", {31'b0, bus_req}, 1);
        bus_finish(0);
        wait_ack("R11");
        @(negedge clk);
        snoop(2'b11, 1, f);
        chk("R11", "kill on E no retry", {31'b0, r_retry}, 0);
        cpu_go(0, f, 1);
        @(negedge clk);
        wait_bus();
        chk("R11", "E invalidated", {31'b0, bus_req}, 1);
        bus_finish(0);
        wait_ack("R11");
        @(negedge clk);
    endtask

    task automatic t_kill_lost();
        logic [15:0] g = mk(4, 5);
        fill(0, g, 1, 1, "R5");
        @(negedge clk);
        cpu_go(1, g, 1);
        @(negedge clk);
        wait_bus();
        chk("R5", "kill issued", {30'b0, bus_op}, 2);
        snoop(2'b11, 1, g);
        chk("R5", "foreign kill no retry", {31'b0, r_retry}, 0);
        bus_finish(0);
        chk("R5", "follow-on req", {31'b0, bus_req}, 1);
        chk("R5", "follow-on rwitm", {30'b0, bus_op}, 1);
        chk("R5", "follow-on addr", {16'b0, bus_addr}, {16'b0, g});
        bus_finish(0);
        wait_ack("R5");
        @(negedge clk);
        snoop(2'b00, 1, g);
        chk("R5", "line Modified", {31'b0, r_retry}, 1);
        cb_finish();
    endtask

    task automatic t_write_victim();
        logic [15:0] h = mk(6, 6), h2 = mk(10, 6), j = mk(1, 7);
        cpu_go(1, h, 1);
        @(negedge clk);
        wait_bus();
        chk("R6", "write miss rwitm", {30'b0, bus_op}, 1);
        chk("R6", "write miss gbl", {31'b0, bus_gbl}, 1);
        bus_finish(1);
        wait_ack("R6");
        @(negedge clk);
        cpu_go(0, h2, 1);
        @(negedge clk);
        wait_bus();
        chk("R7", "victim wback op", {30'b0, bus_op}, 3);
        chk("R7", "victim addr", {16'b0, bus_addr}, {16'b0, h});
        chk("R7", "victim gbl low", {31'b0, bus_gbl}, 0);
        bus_finish(0);
        chk("R7", "then fill op", {30'b0, bus_op}, 0);
        chk("R7", "then fill addr", {16'b0, bus_addr}, {16'b0, h2});
        bus_finish(0);
        wait_ack("R7");
        @(negedge clk);
        snoop(2'b00, 1, h);
        chk("R7", "old line gone", {31'b0, r_retry | r_shared}, 0);
        fill(1, j, 1, 1, "R6");
        @(negedge clk);
        snoop(2'b00, 1, j);
        chk("R6", "write miss gives M", {31'b0, r_retry}, 1);
        cb_finish();
    endtask

    task automatic t_parallel();
        logic [15:0] a = mk(5, 1), f = mk(2, 4), c = mk(3, 2);
        cpu_go(0, a, 1);
        snp_valid = 1; snp_gbl = 1; snp_op = 2'b00; snp_addr = f;
        @(negedge clk);
        chk("R13", "cpu served", {31'b0, cpu_ack}, 1);
        chk("R13", "snoop served", {31'b0, snp_shared}, 1);
        snp_valid = 0; cpu_req = 0;
        @(negedge clk);
        cpu_go(1, c, 0);
        snp_valid = 1; snp_gbl = 1; snp_op = 2'b00; snp_addr = c;
        @(negedge clk);
        chk("R13", "snoop first", {31'b0, snp_shared}, 1);
        chk("R13", "cpu deferred", {31'b0, cpu_ack}, 0);
        snp_valid = 0;
        wait_bus();
        chk("R13", "retaken as kill", {30'b0, bus_op}, 2);
        bus_finish(0);
        wait_ack("R13");
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_read_fill();
        t_copyback();
        t_kill();
        t_snoop_excl();
        t_inval_clean();
        t_kill_lost();
        t_write_victim();
        t_parallel();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule